// File: doc/BRIEF.md
# DSD Bitstream Validity Monitor

This block sits on a one-bit DSD audio stream and judges, bit by bit, whether the stream still looks like real audio. A strobe marks each cycle that carries a new stream bit. The block keeps the last 28 accepted bits and the number of ones among them. From that window two detectors run side by side. The stuck-level detector asks for a mute when the whole window holds one value. The density detector asks for attenuation when one value holds more than 24 of the 28 places, which can happen on a stream that is not fully stuck.

Each detector has its own control input, and the two controls are encoded so that tying both low gives the power-on behaviour: the stuck-level check is on and the density check is off. While either request is active, the outgoing bit is replaced by a zero-average alternating pattern. A bypass input hands the raw bit straight to the output for direct conversion and silences both requests. Downstream mute-pin logic reads the two request flags.

Top module: `dsd_validity_monitor`

## Requirements
- R1: The history, the detector results and `bit_out` change only on a clock edge where `bit_vld` is 1. Each accepted bit is reflected on `bit_out`, `mute_req` and `atten_req` one clock after that edge. With no strobe and steady controls, all outputs hold.
- R2: The stuck-level condition is true when at least 28 bits have been accepted since reset and the last 28 are all 0 or all 1. After 27 accepted bits it is false whatever their value.
- R3: The stuck-level check is active when `static_chk_off` is 0, which is the tie-off value, so it is on out of reset. With the check active and bypass off, `mute_req` equals the stuck-level condition.
- R4: The density condition is true when at least 28 bits have been accepted and the window holds more than 24 ones or fewer than 4 ones.
- R5: The density check is active only when `dens_chk_on` is 1; the tie-off value 0 keeps it off out of reset.
- R6: When a check's control disables it, its flag drops in that same cycle and stays low, whatever the stream does.
- R7: A flag drops on the first accepted bit after which its condition is false. There is no hysteresis.
- R8: When both conditions are true, `mute_req` is 1 and `atten_req` is 0.
- R9: For an accepted bit whose window triggers an active request, `bit_out` carries an idle pattern in place of the input bit: 0 for the first replaced bit, then alternating 1, 0, and so on. The pattern starts again from 0 after any bit that was not replaced.
- R10: With `bypass` at 1, each accepted bit appears unchanged on `bit_out`, and both flags are 0.
- R11: After reset, `bit_out`, `mute_req` and `atten_req` are 0 and the window counts as empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bit_vld | input | 1 | Marks a cycle carrying a new stream bit |
| bit_in | input | 1 | Incoming DSD bit |
| static_chk_off | input | 1 | 1 disables the stuck-level check |
| dens_chk_on | input | 1 | 1 enables the density check |
| bypass | input | 1 | 1 passes bits straight through and clears both requests |
| bit_out | output | 1 | Processed DSD bit |
| mute_req | output | 1 | Stuck-level mute request |
| atten_req | output | 1 | Density attenuate request |

## Verification
A wrong running ones count or fill counter shows at the ports as a flag that rises one bit too early or too late at a window boundary. The bench catches this on the 27th and 28th identical bits after reset and when a run is broken. A wrong idle-phase register shows on `bit_out` at the second replaced bit, so the bench compares every accepted bit through a scoreboard. Control-gating errors show on the flags in the same cycle, with no bit needed, so those are checked with no strobe active.

// File: rtl/dsdmon_pkg.sv
// Package: shared sizing for the DSD validity monitor.
// Assumes: the window length fits comfortably in a small counter.
package dsdmon_pkg;
    // Number of bits held in the sliding history window.
    localparam int unsigned WIN_LEN    = 28;
    // Majority threshold: more than this many equal bits trips density.
    localparam int unsigned DENS_LIMIT = 24;
    // Counter width able to hold 0..WIN_LEN.
    localparam int unsigned CNT_W      = $clog2(WIN_LEN + 1);
endpackage

// File: rtl/dsdmon_window.sv
// Module: dsdmon_window
// Keeps the last WIN accepted bits, a running ones count and a fill
// counter. It exposes the counts that would hold once the bit now on
// bit_in is accepted, so that later stages can act on the same edge.
// Assumes: adv is high for exactly one clock per stream bit.
module dsdmon_window #(
    parameter int unsigned WIN = dsdmon_pkg::WIN_LEN,
    parameter int unsigned CW  = dsdmon_pkg::CNT_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          adv,
    input  logic          bit_in,
    output logic [CW-1:0] ones_nxt,
    output logic          full_nxt
);
    logic [WIN-1:0] hist_q;
    logic [CW-1:0]  ones_q;
    logic [CW-1:0]  fill_q;
    logic [CW-1:0]  fill_nxt;
    logic           leaving;

    // Purpose: bit dropping out of the window (zero until the window is full).
    always_comb begin
        leaving = (fill_q == CW'(WIN)) ? hist_q[WIN-1] : 1'b0;
    end

    // Purpose: count of ones and fill level if the current bit is taken.
    always_comb begin
        ones_nxt = ones_q + {{(CW-1){1'b0}}, bit_in} - {{(CW-1){1'b0}}, leaving};
        fill_nxt = (fill_q == CW'(WIN)) ? fill_q : fill_q + 1'b1;
        full_nxt = (fill_nxt == CW'(WIN));
    end

    // Purpose: shift history and update counters on each accepted bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist_q <= '0;
            ones_q <= '0;
            fill_q <= '0;
        end else if (adv) begin
            hist_q <= {hist_q[WIN-2:0], bit_in};
            ones_q <= ones_nxt;
            fill_q <= fill_nxt;
        end
    end
endmodule

// File: rtl/dsdmon_detect.sv
// Module: dsdmon_detect
// Turns the window counts into the stuck-level and density conditions.
// It gives both the look-ahead result, for output shaping, and the
// result latched at the last accepted bit, for the flags.
// Assumes: the counts come from dsdmon_window with the same WIN.
module dsdmon_detect #(
    parameter int unsigned WIN = dsdmon_pkg::WIN_LEN,
    parameter int unsigned HI  = dsdmon_pkg::DENS_LIMIT,
    parameter int unsigned CW  = dsdmon_pkg::CNT_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          adv,
    input  logic [CW-1:0] ones_nxt,
    input  logic          full_nxt,
    output logic          stuck_nxt,
    output logic          dense_nxt,
    output logic          stuck_q,
    output logic          dense_q
);
    // Fewer ones than this means more than HI zeros.
    localparam int unsigned LO = WIN - HI;

    // Purpose: evaluate both conditions on the look-ahead window.
    always_comb begin
        stuck_nxt = full_nxt && ((ones_nxt == CW'(WIN)) || (ones_nxt == '0));
        dense_nxt = full_nxt && ((ones_nxt > CW'(HI)) || (ones_nxt < CW'(LO)));
    end

    // Purpose: hold the conditions of the window as of the last accepted bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stuck_q <= 1'b0;
            dense_q <= 1'b0;
        end else if (adv) begin
            stuck_q <= stuck_nxt;
            dense_q <= dense_nxt;
        end
    end
endmodule

// File: rtl/dsdmon_shaper.sv
// Module: dsdmon_shaper
// Registers the outgoing bit: the input bit normally, or an alternating
// idle pattern (starting at 0) while replacement is requested.
// Assumes: replace is already forced low by the caller under bypass.
module dsdmon_shaper (
    input  logic clk,
    input  logic rst_n,
    input  logic adv,
    input  logic bit_in,
    input  logic replace,
    output logic bit_out
);
    logic phase_q;

    // Purpose: emit one output bit per accepted input bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_out <= 1'b0;
            phase_q <= 1'b0;
        end else if (adv) begin
            if (replace) begin
                bit_out <= phase_q;
                phase_q <= ~phase_q;
            end else begin
                bit_out <= bit_in;
                phase_q <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/dsd_validity_monitor.sv
// Module: dsd_validity_monitor (top)
// Watches a one-bit DSD stream for stuck levels and one-sided density,
// raises mute / attenuate requests, and substitutes an idle pattern on
// the output while a request is active. Bypass gives raw pass-through.
// Assumes: one stream bit per bit_vld pulse; controls are level signals.
module dsd_validity_monitor #(
    parameter int unsigned WIN = dsdmon_pkg::WIN_LEN,
    parameter int unsigned HI  = dsdmon_pkg::DENS_LIMIT
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_vld,
    input  logic bit_in,
    input  logic static_chk_off,
    input  logic dens_chk_on,
    input  logic bypass,
    output logic bit_out,
    output logic mute_req,
    output logic atten_req
);
    localparam int unsigned CW = $clog2(WIN + 1);

    logic [CW-1:0] ones_nxt;
    logic          full_nxt;
    logic          stuck_nxt;
    logic          dense_nxt;
    logic          stuck_q;
    logic          dense_q;
    logic          stuck_on;
    logic          dense_on;
    logic          replace;

    dsdmon_window #(.WIN(WIN), .CW(CW)) u_win (
        .clk      (clk),
        .rst_n    (rst_n),
        .adv      (bit_vld),
        .bit_in   (bit_in),
        .ones_nxt (ones_nxt),
        .full_nxt (full_nxt)
    );

    dsdmon_detect #(.WIN(WIN), .HI(HI), .CW(CW)) u_det (
        .clk       (clk),
        .rst_n     (rst_n),
        .adv       (bit_vld),
        .ones_nxt  (ones_nxt),
        .full_nxt  (full_nxt),
        .stuck_nxt (stuck_nxt),
        .dense_nxt (dense_nxt),
        .stuck_q   (stuck_q),
        .dense_q   (dense_q)
    );

    // Purpose: gate each check by its control and by bypass.
    always_comb begin
        stuck_on = !static_chk_off && !bypass;
        dense_on = dens_chk_on && !bypass;
        replace  = (stuck_nxt && stuck_on) || (dense_nxt && dense_on);
    end

    // Purpose: drive the flags, mute taking priority over attenuate.
    always_comb begin
        mute_req  = stuck_q && stuck_on;
        atten_req = dense_q && dense_on && !mute_req;
    end

    dsdmon_shaper u_shp (
        .clk     (clk),
        .rst_n   (rst_n),
        .adv     (bit_vld),
        .bit_in  (bit_in),
        .replace (replace),
        .bit_out (bit_out)
    );
endmodule

// File: rtl/dsdmon_checker.sv
// Module: dsdmon_checker
// Property checks for dsd_validity_monitor, bound to every instance.
// Keeps its own run-length counter, independent of the design's window.
module dsdmon_checker #(
    parameter int unsigned WIN = dsdmon_pkg::WIN_LEN
) (
    input logic clk,
    input logic rst_n,
    input logic bit_vld,
    input logic bit_in,
    input logic static_chk_off,
    input logic dens_chk_on,
    input logic bypass,
    input logic bit_out,
    input logic mute_req,
    input logic atten_req
);
    localparam int unsigned CW = $clog2(WIN + 1);

    logic [CW-1:0] run_q;
    logic          last_q;

    // Purpose: length of the current run of equal accepted bits, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q  <= '0;
            last_q <= 1'b0;
        end else if (bit_vld) begin
            last_q <= bit_in;
            if (run_q != '0 && bit_in == last_q)
                run_q <= (run_q == CW'(WIN)) ? run_q : run_q + 1'b1;
            else
                run_q <= CW'(1);
        end
    end

    assert_run_mutes_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q == CW'(WIN) && !static_chk_off && !bypass) |-> mute_req);

    assert_mute_needs_run_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mute_req |-> (run_q == CW'(WIN)));

    assert_hold_between_bits_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(bit_vld) && $stable(static_chk_off) && $stable(dens_chk_on) && $stable(bypass))
        |-> ($stable(bit_out) && $stable(mute_req) && $stable(atten_req)));

    assert_disabled_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (static_chk_off |-> !mute_req) and (!dens_chk_on |-> !atten_req));

    assert_mute_priority_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mute_req, atten_req}));

    assert_bypass_pass_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_vld && bypass) |=> (bit_out == $past(bit_in)));
endmodule

bind dsd_validity_monitor dsdmon_checker #(.WIN(WIN)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .bit_vld        (bit_vld),
    .bit_in         (bit_in),
    .static_chk_off (static_chk_off),
    .dens_chk_on    (dens_chk_on),
    .bypass         (bypass),
    .bit_out        (bit_out),
    .mute_req       (mute_req),
    .atten_req      (atten_req)
);

// File: tb/sim_dsd_validity_monitor.sv
// Bench: scoreboard over accepted bits plus direct checks of the flags.
module sim_dsd_validity_monitor;
    localparam int CLK_PERIOD = 10;
    localparam int WIN = 28;
    localparam int HI  = 24;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bit_vld = 1'b0;
    logic bit_in = 1'b0;
    logic static_chk_off = 1'b0;
    logic dens_chk_on = 1'b0;
    logic bypass = 1'b0;
    logic bit_out, mute_req, atten_req;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    typedef struct {
        logic  o;
        logic  m;
        logic  a;
        string tag;
    } exp_t;
    exp_t exp_q[$];

    logic hist_m[$];
    logic phase_m = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dsd_validity_monitor u0 (
        .clk(clk), .rst_n(rst_n), .bit_vld(bit_vld), .bit_in(bit_in),
        .static_chk_off(static_chk_off), .dens_chk_on(dens_chk_on), .bypass(bypass),
        .bit_out(bit_out), .mute_req(mute_req), .atten_req(atten_req)
    );

    task automatic check(string tag, logic act, logic expv, string what);
        n_cmp++;
        if (act !== expv) begin
            n_bad++;
            $display("FAIL %s %s: actual %b expected %b at %0t", tag, what, act, expv, $time);
        end
    endtask

    // Driver: present one bit and push the expected result from the model.
    task automatic send(logic b, string tag);
        int ones;
        bit full, st, dn;
        exp_t e;
        @(negedge clk);
        bit_in  = b;
        bit_vld = 1'b1;
        hist_m.push_back(b);
        if (hist_m.size() > WIN) void'(hist_m.pop_front());
        ones = 0;
        foreach (hist_m[i]) ones += int'(hist_m[i]);
        full = (hist_m.size() == WIN);
        st = full && (ones == WIN || ones == 0);
        dn = full && (ones > HI || ones < WIN - HI);
        e.m = st && !static_chk_off && !bypass;
        e.a = dn && dens_chk_on && !bypass && !e.m;
        if (e.m || e.a) begin
            e.o = phase_m;
            phase_m = ~phase_m;
        end else begin
            e.o = b;
            phase_m = 1'b0;
        end
        e.tag = tag;
        exp_q.push_back(e);
        @(negedge clk);
        bit_vld = 1'b0;
    endtask

    task automatic send_run(logic b, int n, string tag);
        for (int i = 0; i < n; i++) send(b, tag);
    endtask

    // Monitor: after each accepted edge, compare outputs with the queue head.
    always @(posedge clk) begin
        if (bit_vld && rst_n) begin
            #2;
            if (exp_q.size() == 0) begin
                n_cmp++; n_bad++;
                $display("FAIL R1 unexpected output: actual bit %b expected none", bit_out);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check(e.tag, bit_out, e.o, "bit_out");
                check(e.tag, mute_req, e.m, "mute_req");
                check(e.tag, atten_req, e.a, "atten_req");
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        @(negedge clk);
        check("R11", bit_out, 1'b0, "bit_out after reset");
        check("R11", mute_req, 1'b0, "mute_req after reset");
        check("R11", atten_req, 1'b0, "atten_req after reset");

        // R2/R3: 27 zeros do not fill the window; the 28th mutes; idle pattern R9.
        send_run(1'b0, 27, "R2");
        send_run(1'b0, 4, "R3_R9");

        // R1: flags and output hold with no strobe.
        repeat (4) @(negedge clk);
        check("R1", mute_req, 1'b1, "mute_req held");

        // R6: disabling the stuck-level check drops mute at once.
        static_chk_off = 1'b1;
        #1 check("R6", mute_req, 1'b0, "mute_req with check off");
        @(negedge clk) static_chk_off = 1'b0;
        #1 check("R6", mute_req, 1'b1, "mute_req re-enabled");

        // R7: one differing bit ends the stuck condition.
        send(1'b1, "R7");

        // Balanced stream clears everything.
        dens_chk_on = 1'b1;
        for (int i = 0; i < 30; i++) send(logic'(i % 2), "R4_balanced");

        // R4/R8: long run of ones: attenuate first, then mute takes over.
        send_run(1'b1, 30, "R8");
        send(1'b0, "R7_R4");

        // R4: mostly ones, never stuck.
        for (int i = 0; i < 42; i++) send(logic'((i % 14) != 13), "R4");

        // R6/R5: density check off.
        dens_chk_on = 1'b0;
        #1 check("R6", atten_req, 1'b0, "atten_req with check off");
        for (int i = 0; i < 14; i++) send(logic'((i % 14) != 13), "R5");

        // R4 with stuck-level off: zeros run gives attenuate only.
        static_chk_off = 1'b1;
        dens_chk_on = 1'b1;
        send_run(1'b0, 30, "R4_low");

        // R10: bypass clears flags and passes bits.
        @(negedge clk) bypass = 1'b1;
        #1 check("R10", atten_req, 1'b0, "atten_req under bypass");
        static_chk_off = 1'b0;
        send_run(1'b0, 30, "R10");
        send(1'b1, "R10");
        bypass = 1'b0;
        for (int i = 0; i < 40; i++) send(logic'(i % 2), "R7_clear");

        repeat (4) @(negedge clk);
        if (exp_q.size() != 0) begin
            n_cmp++; n_bad++;
            $display("FAIL R1 pending results: actual %0d expected 0", exp_q.size());
        end
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule